// File: doc/BRIEF.md
# Static Branch Direction and Next-Fetch Predictor

This block decides, within the same cycle, whether a conditional branch in the fetch stage should be treated as taken. It also produces the address that fetch should use next. The rule is picked at run time by a two-bit selector and is one of four fixed policies:

- fall through always;
- redirect always;
- redirect only for backward branches, judged from the sign of the offset;
- follow a one-bit hint that the compiler placed in the instruction.

No policy learns from earlier branches, so the same inputs always give the same answer.

A small registered tally sits beside the combinational path. It holds the most recent prediction until the branch resolves, then counts the resolved branch and, if the prediction was wrong, a miss. Running the same branch trace once per selector setting and reading the two counters gives each policy's accuracy.

The tally is a two-state machine. In IDLE no prediction is outstanding. In PENDING a prediction is held. The transitions are:

- CAPTURE (IDLE to PENDING) happens when a valid branch is seen.
- RETIRE (PENDING to IDLE) happens when a resolve strobe arrives and no new branch is present.
- REPLACE (PENDING to PENDING) happens when a new valid branch arrives. If a resolve strobe comes in the same cycle, it is scored against the old held prediction first.
- HOLD keeps the current state in every other case.

Top module: `static_bp_top`

## Requirements
- R1: With `mode_i` = 2'b00 (fall-through), `pred_taken_o` is 0 and `next_pc_o` is `pc_i` + 4 for every branch.
- R2: With `mode_i` = 2'b01 (always redirect) and `br_valid_i` high, `pred_taken_o` is 1 and `next_pc_o` is `pc_i` plus the sign-extended `br_offset_i`.
- R3: With `mode_i` = 2'b10 (direction) and `br_valid_i` high, `pred_taken_o` equals bit 19 of `br_offset_i`. A negative offset is predicted taken. A zero or positive offset is predicted not taken.
- R4: With `mode_i` = 2'b11 (hint) and `br_valid_i` high, `pred_taken_o` equals `hint_i`.
- R5: When `br_valid_i` is low, `pred_taken_o` is 0 and `next_pc_o` is `pc_i` + 4, whatever the mode, offset or hint.
- R6: `next_pc_o` is the target when the prediction is taken and `pc_i` + 4 otherwise. Both sums wrap modulo 2^32.
- R7: A resolve strobe in PENDING raises `branch_cnt_o` by one at the next clock edge. The state returns to IDLE unless a new valid branch is present in the same cycle.
- R8: A resolve in PENDING raises `mispred_cnt_o` by one when `outcome_i` differs from the held prediction. The held prediction is the one latched with the most recent valid branch before that cycle.
- R9: A resolve strobe in IDLE changes neither counter.
- R10: With `rst` high at a clock edge, both counters become 0 and the state becomes IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pc_i | input | 32 | Address of the instruction in fetch |
| br_valid_i | input | 1 | The instruction is a conditional branch |
| br_offset_i | input | 20 | Signed branch displacement in bytes |
| hint_i | input | 1 | Compiler direction hint, 1 means taken |
| mode_i | input | 2 | Policy selector |
| resolve_i | input | 1 | Strobe: the held branch has resolved |
| outcome_i | input | 1 | Actual direction of the resolved branch, 1 means taken |
| pred_taken_o | output | 1 | Predicted direction |
| next_pc_o | output | 32 | Predicted next fetch address |
| branch_cnt_o | output | 32 | Count of resolved branches |
| mispred_cnt_o | output | 32 | Count of resolved branches that were mispredicted |

## Verification
The hardest situation to reach from the ports is a resolve strobe arriving in the same cycle as a new valid branch. The counter must score the older held prediction while the newer one is latched. Random traces rarely line this up with a prediction that differs from the outcome, so directed steps force it with opposite directions on the two branches. Further directed steps cover a resolve while IDLE, a zero offset in direction mode, the most negative offset, and an address that wraps past the top of memory. Several thousand random cycles then mix all four modes against the bench's own model.

// File: rtl/static_bp_pkg.sv
package static_bp_pkg;

    typedef enum logic [1:0] {
        POL_FALLTHRU = 2'b00,
        POL_ALWAYS   = 2'b01,
        POL_DIRECT   = 2'b10,
        POL_HINT     = 2'b11
    } policy_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PENDING = 1'b1
    } tally_state_e;

endpackage

// File: rtl/bp_policy.sv
module bp_policy
    import static_bp_pkg::*;
#(
    parameter int OFF_W = 20
) (
    input  logic [1:0]       mode_i,
    input  logic             valid_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic             hint_i,
    output logic             taken_o
);
    localparam int SIGN_BIT = OFF_W - 1;

    policy_e pol;
    logic    raw_dir;

    assign pol = policy_e'(mode_i);

    always_comb begin
        unique case (pol)
            POL_FALLTHRU: raw_dir = 1'b0;
            POL_ALWAYS:   raw_dir = 1'b1;
            POL_DIRECT:   raw_dir = offset_i[SIGN_BIT];
            POL_HINT:     raw_dir = hint_i;
            default:      raw_dir = 1'b0;
        endcase
    end

    assign taken_o = valid_i & raw_dir;

endmodule

// File: rtl/bp_nextpc.sv
module bp_nextpc #(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 20,
    parameter int INSTR_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFF_W-1:0]  offset_i,
    input  logic              taken_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam int                EXT_W = ADDR_W - OFF_W;
    localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_BYTES);

    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] tgt_addr;
    logic [ADDR_W-1:0] off_ext;

    assign off_ext   = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
    assign seq_addr  = pc_i + STEP;
    assign tgt_addr  = pc_i + off_ext;
    assign next_pc_o = taken_i ? tgt_addr : seq_addr;

endmodule

// File: rtl/bp_tally.sv
module bp_tally
    import static_bp_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic             pred_i,
    input  logic             resolve_i,
    input  logic             outcome_i,
    output logic [CNT_W-1:0] branch_cnt_o,
    output logic [CNT_W-1:0] miss_cnt_o
);
    tally_state_e state_q, state_d;
    logic         held_pred_q;
    logic         score;
    logic         miss;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions: CAPTURE, RETIRE, REPLACE, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (valid_i) state_d = ST_PENDING;        // CAPTURE
            ST_PENDING: begin
                if (valid_i)        state_d = ST_PENDING;         // REPLACE
                else if (resolve_i) state_d = ST_IDLE;            // RETIRE
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs of the machine: scoring strobes
    always_comb begin
        score = 1'b0;
        miss  = 1'b0;
        unique case (state_q)
            ST_IDLE:    score = 1'b0;
            ST_PENDING: begin
                score = resolve_i;
                miss  = resolve_i & (held_pred_q ^ outcome_i);
            end
            default:    score = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_pred_q  <= 1'b0;
            branch_cnt_o <= '0;
            miss_cnt_o   <= '0;
        end else begin
            if (valid_i) held_pred_q  <= pred_i;
            if (score)   branch_cnt_o <= branch_cnt_o + 1'b1;
            if (miss)    miss_cnt_o   <= miss_cnt_o + 1'b1;
        end
    end

    AST_RESOLVE_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING && resolve_i) |=> branch_cnt_o == $past(branch_cnt_o) + 1'b1); // R7
    AST_IDLE_RESOLVE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && resolve_i) |=> ($stable(branch_cnt_o) && $stable(miss_cnt_o))); // R9
    AST_MISS_WITH_BRANCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING && resolve_i && (held_pred_q != outcome_i))
        |=> miss_cnt_o == $past(miss_cnt_o) + 1'b1); // R8
    AST_NO_MISS_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PENDING && resolve_i && (held_pred_q == outcome_i))
        |=> $stable(miss_cnt_o)); // R8

endmodule

// File: rtl/static_bp_top.sv
module static_bp_top
    import static_bp_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int OFF_W       = 20,
    parameter int INSTR_BYTES = 4,
    parameter int CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              br_valid_i,
    input  logic [OFF_W-1:0]  br_offset_i,
    input  logic              hint_i,
    input  logic [1:0]        mode_i,
    input  logic              resolve_i,
    input  logic              outcome_i,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] next_pc_o,
    output logic [CNT_W-1:0]  branch_cnt_o,
    output logic [CNT_W-1:0]  mispred_cnt_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic taken;

    bp_policy #(.OFF_W(OFF_W)) u_policy (
        .mode_i   (mode_i),
        .valid_i  (br_valid_i),
        .offset_i (br_offset_i),
        .hint_i   (hint_i),
        .taken_o  (taken)
    );

    bp_nextpc #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .INSTR_BYTES(INSTR_BYTES)) u_nextpc (
        .pc_i      (pc_i),
        .offset_i  (br_offset_i),
        .taken_i   (taken),
        .next_pc_o (next_pc_o)
    );

    bp_tally #(.CNT_W(CNT_W)) u_tally (
        .clk          (clk),
        .rst          (rst),
        .valid_i      (br_valid_i),
        .pred_i       (taken),
        .resolve_i    (resolve_i),
        .outcome_i    (outcome_i),
        .branch_cnt_o (branch_cnt_o),
        .miss_cnt_o   (mispred_cnt_o)
    );

    assign pred_taken_o = taken;

    AST_INVALID_FALLS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !br_valid_i |-> (!pred_taken_o && next_pc_o == pc_i + STEP)); // R5
    AST_FALLTHRU_NEVER_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (mode_i == POL_FALLTHRU) |-> !pred_taken_o); // R1
    AST_DIRECT_SIGN: assert property (@(posedge clk) disable iff (rst)
        (br_valid_i && mode_i == POL_DIRECT) |-> pred_taken_o == br_offset_i[OFF_W-1]); // R3
    AST_HINT_FOLLOWED: assert property (@(posedge clk) disable iff (rst)
        (br_valid_i && mode_i == POL_HINT) |-> pred_taken_o == hint_i); // R4
    AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (br_valid_i && mode_i == POL_ALWAYS) |-> pred_taken_o); // R2
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (branch_cnt_o == '0 && mispred_cnt_o == '0)); // R10

endmodule

// File: tb/test_static_bp_top.sv
`timescale 1ns/1ps
module test_static_bp_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] pc;
    logic        bv;
    logic [19:0] off;
    logic        hint;
    logic [1:0]  mode;
    logic        res;
    logic        outc;
    logic        pred;
    logic [31:0] npc;
    logic [31:0] bcnt;
    logic [31:0] mcnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // model state
    bit          m_pend;
    bit          m_held;
    logic [31:0] m_bc;
    logic [31:0] m_mc;

    static_bp_top i_static_bp_top (
        .clk(clk), .rst(rst), .pc_i(pc), .br_valid_i(bv), .br_offset_i(off),
        .hint_i(hint), .mode_i(mode), .resolve_i(res), .outcome_i(outc),
        .pred_taken_o(pred), .next_pc_o(npc), .branch_cnt_o(bcnt), .mispred_cnt_o(mcnt)
    );

    always #2.5 clk = ~clk;

    function automatic bit exp_pred(input logic [1:0] m, input bit v,
                                    input logic [19:0] o, input bit h);
        if (!v) return 1'b0;
        case (m)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return o[19];
            default: return h;
        endcase
    endfunction

    function automatic logic [31:0] exp_npc(input logic [31:0] p, input logic [19:0] o, input bit t);
        logic [31:0] se;
        se = {{12{o[19]}}, o};
        return t ? p + se : p + 32'd4;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic string req_of(input logic [1:0] m, input bit v);
        if (!v) return "R5";
        case (m)
            2'b00:   return "R1";
            2'b01:   return "R2";
            2'b10:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // one cycle: drive at negedge, check, then model the edge
    task automatic step(input logic [31:0] p, input bit v, input logic [19:0] o,
                        input bit h, input logic [1:0] m, input bit r, input bit oc);
        bit ep;
        @(negedge clk);
        pc = p; bv = v; off = o; hint = h; mode = m; res = r; outc = oc;
        #1;
        ep = exp_pred(m, v, o, h);
        chk(req_of(m, v), {31'd0, pred}, {31'd0, ep});
        chk("R6", npc, exp_npc(p, o, ep));
        chk("R7", bcnt, m_bc);
        chk("R8", mcnt, m_mc);
        if (m_pend && r) begin
            m_bc++;
            if (m_held != oc) m_mc++;
        end
        if (v) begin
            m_pend = 1'b1;
            m_held = ep;
        end else if (r) begin
            m_pend = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bv = 1'b0; res = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pend = 1'b0; m_held = 1'b0; m_bc = '0; m_mc = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; pc = '0; bv = 0; off = '0; hint = 0; mode = 0; res = 0; outc = 0;
        m_pend = 0; m_held = 0; m_bc = '0; m_mc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R10", bcnt, 32'd0);
        chk("R10", mcnt, 32'd0);

        // R9: resolve while idle ignored
        step(32'h100, 0, 20'h0, 0, 2'b01, 1, 1);
        step(32'h104, 0, 20'h0, 0, 2'b01, 1, 0);
        // R3: zero offset forward, most negative offset backward
        step(32'h200, 1, 20'h00000, 1, 2'b10, 0, 0);
        step(32'h200, 1, 20'h80000, 0, 2'b10, 1, 0);
        // R6: wrap past top of memory
        step(32'hFFFF_FFFC, 1, 20'h0, 0, 2'b00, 1, 1);
        step(32'hFFFF_FFF0, 1, 20'h00020, 0, 2'b01, 1, 0);
        // R8: resolve plus new branch, opposite directions
        step(32'h300, 1, 20'h00010, 1, 2'b11, 1, 0);
        step(32'h304, 1, 20'h00010, 0, 2'b11, 1, 0);
        step(32'h308, 0, 20'h00010, 1, 2'b11, 1, 1);
        // R5: invalid branch ignores mode and hint
        step(32'h400, 0, 20'hFFFF0, 1, 2'b01, 0, 0);
        step(32'h404, 0, 20'hFFFF0, 1, 2'b11, 0, 0);
        step(32'h408, 0, 20'h0, 0, 2'b00, 0, 0);

        // random traces
        for (int i = 0; i < 4000; i++) begin
            step($urandom, ($urandom % 4) != 0, 20'($urandom), 1'($urandom),
                 2'($urandom), ($urandom % 3) == 0, 1'($urandom));
        end

        // R10: reset mid-run clears counters
        do_reset();
        #1;
        chk("R10", bcnt, 32'd0);
        chk("R10", mcnt, 32'd0);
        step(32'h500, 0, 20'h0, 0, 2'b00, 1, 1);
        step(32'h504, 0, 20'h0, 0, 2'b00, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule